// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block builds the word a host sees when it reads a nonvolatile array while an internal program or erase is running. When no operation is running, a read returns the true array data. While an operation is busy, the read path replaces the data with a status word. One bit, the polling bit, carries the inverse of the value being programmed, or a zero during an erase. A second bit, the toggle bit, changes value on every read. The host can therefore detect completion by reading, without watching a ready pin.

An active-low ready/busy output follows the busy flag for hosts that prefer a pin. The array storage and the command decoder sit outside the block. The decoder supplies the busy flag, the operation type and the polled bit of the last loaded data. The array supplies the true read data.

A read is taken on the rising edge of the qualified read enable. The returned word is captured in a register at that clock edge and held until the next read.

Top module: `osg_status_gen`

## Requirements
- R1: After reset, `rd_data` is all zeros, `busy_n` is 1 and the toggle state is 0, so the first busy read returns 0 on the toggle bit.
- R2: A read is taken only on a clock edge where `rd_en` is 1 and was 0 at the previous edge. `rd_data` is updated at that edge and holds its value until the next read. Keeping `rd_en` high takes no further reads, even when the array data or the busy flag changes.
- R3: When a read is taken with `busy`=1 and `op_erase`=0 (program), bit 7 (`POLL_BIT`) of `rd_data` is the inverse of `poll_src`.
- R4: When a read is taken with `busy`=1 and `op_erase`=1 (chip or sector erase), bit 7 of `rd_data` is 0.
- R5: Each read taken with `busy`=1 returns the toggle state on bit 6 (`TOG_BIT`) and then inverts that state. The state carries over from one operation to the next.
- R6: When a read is taken with `busy`=1, every bit of `rd_data` other than bits 7 and 6 is 0.
- R7: When a read is taken with `busy`=0, `rd_data` equals `array_data`. Reads while idle leave the toggle state unchanged.
- R8: `busy_n` goes to 0 one clock after `busy` goes to 1, and returns to 1 one clock after `busy` goes to 0.
- R9: The read is judged against `busy` at the capture edge. A read in the cycle where `busy` falls returns true data. A read in the cycle where `busy` rises returns status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | Internal program or erase in progress |
| op_erase | input | 1 | Operation type: 1 = erase, 0 = program |
| poll_src | input | 1 | Bit 7 of the last loaded program data |
| rd_en | input | 1 | Qualified read enable (chip select and output enable both active) |
| array_data | input | DATA_W | True data read from the array |
| rd_data | output | DATA_W | Captured read data or status word |
| busy_n | output | 1 | Ready/busy, low while an operation runs |

## Verification
Two events can land on the same clock edge: a read strobe and a change of the busy flag. The bench covers both directions. It raises `rd_en` in the cycle where `busy` falls and expects true array data with `busy_n` back at 1. It also raises `rd_en` in the cycle where `busy` rises and expects a status word with `busy_n` at 0. The scoreboard tracks the toggle state on its own, so a read that advanced the toggle wrongly at either boundary shows up as a bit 6 mismatch on the next busy read.

// File: rtl/osg_pkg.sv
package osg_pkg;

   typedef enum logic {
      OSG_OP_PROGRAM = 1'b0,
      OSG_OP_ERASE   = 1'b1
   } osg_op_e;

   localparam int OSG_MIN_WIDTH = 2;

endpackage

// File: rtl/osg_read_edge.sv
module osg_read_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_en,
   output logic strobe
);

   logic rd_en_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_en_prev_q <= 1'b0;
      else        rd_en_prev_q <= rd_en;
   end

   assign strobe = rd_en & ~rd_en_prev_q;

   // R2: a held enable yields a single strobe
   p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe);

endmodule

// File: rtl/osg_toggle.sv
module osg_toggle #(
   parameter logic TOG_INIT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic busy,
   output logic tog_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              tog_q <= TOG_INIT;
      else if (strobe && busy) tog_q <= ~tog_q;
   end

   // R5: a busy read advances the toggle
   p_toggle_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && busy) |=> (tog_q != $past(tog_q)));

   // R7: idle reads and idle clocks leave it alone
   p_toggle_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(strobe && busy) |=> $stable(tog_q));

endmodule

// File: rtl/osg_status_word.sv
module osg_status_word #(
   parameter int DATA_W   = 8,
   parameter int POLL_BIT = 7,
   parameter int TOG_BIT  = 6
) (
   input  osg_pkg::osg_op_e    op,
   input  logic                poll_src,
   input  logic                tog,
   output logic [DATA_W-1:0]   status
);

   localparam logic POLL_ERASE = 1'b0;

   generate
      if (DATA_W < osg_pkg::OSG_MIN_WIDTH) begin : g_bad_width
         $error("osg_status_word: DATA_W too small");
      end
      if (POLL_BIT >= DATA_W || TOG_BIT >= DATA_W) begin : g_bad_pos
         $error("osg_status_word: status bit outside data word");
      end
      if (POLL_BIT == TOG_BIT) begin : g_bad_overlap
         $error("osg_status_word: polling and toggle bits coincide");
      end
   endgenerate

   genvar b;
   generate
      for (b = 0; b < DATA_W; b++) begin : g_bit
         if (b == POLL_BIT) begin : g_poll
            assign status[b] = (op == osg_pkg::OSG_OP_ERASE) ? POLL_ERASE : ~poll_src;
         end else if (b == TOG_BIT) begin : g_tog
            assign status[b] = tog;
         end else begin : g_pad
            assign status[b] = 1'b0;
         end
      end
   endgenerate

   // R6: status padding bits stay clear
   always_comb begin
      a_pad_zero_r6: assert ((status & ~((DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOG_BIT))) == '0);
   end

endmodule

// File: rtl/osg_status_gen.sv
module osg_status_gen #(
   parameter int   DATA_W   = 8,
   parameter int   POLL_BIT = 7,
   parameter int   TOG_BIT  = 6,
   parameter logic TOG_INIT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              op_erase,
   input  logic              poll_src,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy_n
);

   logic              strobe;
   logic              tog;
   logic [DATA_W-1:0] status;
   logic [DATA_W-1:0] rd_data_q;
   logic              busy_n_q;
   osg_pkg::osg_op_e  op;

   assign op = osg_pkg::osg_op_e'(op_erase);

   osg_read_edge i_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_en  (rd_en),
      .strobe (strobe)
   );

   osg_toggle #(.TOG_INIT(TOG_INIT)) i_toggle (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (strobe),
      .busy   (busy),
      .tog_q  (tog)
   );

   osg_status_word #(
      .DATA_W   (DATA_W),
      .POLL_BIT (POLL_BIT),
      .TOG_BIT  (TOG_BIT)
   ) i_word (
      .op       (op),
      .poll_src (poll_src),
      .tog      (tog),
      .status   (status)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_data_q <= '0;
      else if (strobe) rd_data_q <= busy ? status : array_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_n_q <= 1'b1;
      else        busy_n_q <= ~busy;
   end

   assign rd_data = rd_data_q;
   assign busy_n  = busy_n_q;

   // R8: ready/busy follows the busy flag one clock later
   p_busy_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy_n);
   p_busy_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> busy_n);

   // R2: output held between reads
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> $stable(rd_data));

   // R3: program polling bit is inverted
   p_prog_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && busy && !op_erase) |=> (rd_data[POLL_BIT] == !$past(poll_src)));

   // R4: erase polling bit reads zero
   p_erase_poll_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && busy && op_erase) |=> (rd_data[POLL_BIT] == 1'b0));

   // R7, R9: idle read returns true data
   p_idle_true_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !busy) |=> (rd_data == $past(array_data)));

endmodule

// File: tb/test_osg_status_gen.sv
module test_osg_status_gen;

   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          busy = 1'b0;
   logic          op_erase = 1'b0;
   logic          poll_src = 1'b0;
   logic          rd_en = 1'b0;
   logic [DW-1:0] array_data = '0;
   logic [DW-1:0] rd_data;
   logic          busy_n;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   logic mtog = 1'b0;

   typedef struct {
      int          due;
      logic [DW-1:0] d;
      logic        bn;
      string       req;
   } exp_t;

   exp_t sb[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   osg_status_gen #(.DATA_W(DW)) i_osg_status_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy       (busy),
      .op_erase   (op_erase),
      .poll_src   (poll_src),
      .rd_en      (rd_en),
      .array_data (array_data),
      .rd_data    (rd_data),
      .busy_n     (busy_n)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // expected word from the requirements; advances the model toggle
   function automatic logic [DW-1:0] model(input logic b, input logic er, input logic [7:0] last,
                                            input logic [DW-1:0] arr);
      logic [DW-1:0] w;
      if (!b) return arr;                       // R7
      w = '0;                                   // R6
      w[7] = er ? 1'b0 : ~last[7];              // R3 / R4
      w[6] = mtog;                              // R5
      mtog = ~mtog;
      return w;
   endfunction

   task automatic push(input logic [DW-1:0] d, input logic bn, input string req);
      exp_t e;
      e.due = cyc + 1;
      e.d   = d;
      e.bn  = bn;
      e.req = req;
      sb.push_back(e);
   endtask

   // driver: one read with the given conditions on the capture edge
   task automatic do_read(input logic b, input logic er, input logic [7:0] last,
                          input logic [DW-1:0] arr, input string req);
      logic [DW-1:0] w;
      @(negedge clk);
      busy = b; op_erase = er; poll_src = last[7]; array_data = arr; rd_en = 1'b1;
      w = model(b, er, last, arr);
      push(w, ~b, req);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   // monitor
   initial begin
      forever begin
         @(negedge clk);
         while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            check(rd_data == e.d, e.req, 32'(rd_data), 32'(e.d));
            check(busy_n == e.bn, {e.req, " R8"}, 32'(busy_n), 32'(e.bn));
         end
      end
   end

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [DW-1:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(rd_data == '0, "R1 rd_data", 32'(rd_data), 0);
      check(busy_n == 1'b1, "R1 busy_n", 32'(busy_n), 1);

      // R7 idle reads
      do_read(1'b0, 1'b0, 8'h00, 8'h3C, "R7 idle");
      do_read(1'b0, 1'b0, 8'h00, 8'hC3, "R7 idle");

      // R3 R5 R6 program polling
      do_read(1'b1, 1'b0, 8'h80, 8'hFF, "R3 R5 R6 prog");
      do_read(1'b1, 1'b0, 8'h80, 8'hFF, "R3 R5 prog");
      do_read(1'b1, 1'b0, 8'h7F, 8'hAA, "R3 R5 R6 prog");

      // R8 busy_n settles high while idle, and idle reads freeze toggle (R7)
      @(negedge clk); busy = 1'b0;
      @(negedge clk);
      check(busy_n == 1'b1, "R8 release", 32'(busy_n), 1);
      do_read(1'b0, 1'b0, 8'h00, 8'hA5, "R7 idle");
      do_read(1'b0, 1'b0, 8'h00, 8'h5A, "R7 idle");

      // R4 erase polling, toggle continues from program (R5)
      do_read(1'b1, 1'b1, 8'hFF, 8'h00, "R4 R5 erase");
      do_read(1'b1, 1'b1, 8'h00, 8'hFF, "R4 R5 R6 erase");
      @(negedge clk);
      check(busy_n == 1'b0, "R8 busy", 32'(busy_n), 0);

      // R9 read lands where busy falls
      do_read(1'b0, 1'b1, 8'h00, 8'h96, "R9 fall");
      // R9 read lands where busy rises
      do_read(1'b1, 1'b0, 8'h00, 8'h77, "R9 rise R3");

      // R2 held enable: no further reads
      @(negedge clk);
      busy = 1'b0; array_data = 8'h11; rd_en = 1'b1;
      held = model(1'b0, 1'b0, 8'h00, 8'h11);
      push(held, 1'b1, "R2 first");
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         array_data = 8'(8'h22 + i);
         busy = (i == 2);
         push(held, ~busy, "R2 hold");
      end
      @(negedge clk);
      busy = 1'b1; rd_en = 1'b0;
      push(held, 1'b0, "R2 hold");
      // toggle untouched by the held enable
      do_read(1'b1, 1'b0, 8'h80, 8'h00, "R2 R5 after hold");
      @(negedge clk); busy = 1'b0;

      repeat (3) @(negedge clk);
      check(sb.size() == 0, "scoreboard drained", 32'(sb.size()), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule